// File: doc/BRIEF.md
# ADC Sample Stream Serializer

This block packs up to four single-bit sample lanes from a converter into one serial line for a baseband processor. The whole block runs on the serial clock. A one-cycle strobe marks each converter sample. Each lane keeps the last sixteen strobed bits in its own holding register. When the sixteenth sample of a window arrives, all holding registers are handed over together to per-lane shift registers. During the following window the selected lanes then go out back to back, as sixteen-bit slices.

A two-bit lane select picks which lanes are sent. The line is driven low once the last selected slice has been sent and stays low until the next window begins. A slice marker flags the first bit of every valid slice. A separate time marker pulses once every programmable number of sample strobes. A sticky flag records when a new window arrives before the previous one has finished, which happens when the serial clock is too slow for the chosen lane count.

Top module: `sample_stream_serializer`

## Requirements
- R1: Lane bits are captured only in cycles where `smp_stb` is high; `smp_bits` is ignored in every other cycle. A window is made of exactly 16 strobed samples, counted from reset.
- R2: On the clock edge that samples the 16th strobe of a window, the window is loaded for output. `ser_dout` carries its first bit in the cycle right after that edge. Within a slice, the sample strobed first goes out first, one bit per clock.
- R3: `stream_sel` selects the slice order. 0 sends lane 0 only. 1 sends lane 0 then lane 1. 2 sends lane 0 then lane 2. 3 sends lanes 0, 1, 2, 3 in that order. The select is sampled only on the loading edge and holds for that whole window.
- R4: Once all selected slices of a window have been sent, `ser_dout` is 0 until the next window is loaded.
- R5: `slice_sync` is high exactly during the first bit of each valid slice and low in every other cycle.
- R6: `time_sync` is a one-cycle pulse in the cycle after the edge that samples every N-th strobe. The strobe counter starts from reset. N is the effective period.
- R7: The effective period is `ts_period` limited to the range 128 to 16384: smaller values act as 128 and larger values act as 16384.
- R8: `overrun` is set, and stays set until reset, when a window is loaded before the last bit of the previous window's last selected slice has been sent. A window loaded exactly in the cycle after that last bit does not set it.
- R9: While reset is held, all outputs are 0. After reset, 16 fresh strobes are needed before any data goes out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset |
| smp_stb | input | 1 | One-cycle strobe marking a converter sample |
| smp_bits | input | LANES (4) | One sample bit per lane, taken when `smp_stb` is high |
| stream_sel | input | 2 | Lane subset and order, sampled at window load |
| ts_period | input | PER_W (15) | Requested time-marker period in strobes |
| ser_dout | output | 1 | Serial data, zero-filled after the valid slices |
| slice_sync | output | 1 | High during the first bit of each valid slice |
| time_sync | output | 1 | Periodic one-cycle time marker |
| overrun | output | 1 | Sticky flag: a window started before the previous one finished |

## Verification
The bound checker watches, in every cycle, that each window load is followed at once by a slice marker, that slice and time markers last one cycle, that a time marker always follows a strobe, and that the overrun flag only rises after a load and never clears. The actual serial bit values, the slice order for each select code, the zero fill, the period clamp and the exact rate boundary for overrun can only be seen by comparing against the bench's model of the sampled lanes. The bench runs several strobe spacings and select codes, including one where the select changes in the middle of a window.

// File: rtl/ssr_pkg.sv
`timescale 1ns/1ps
package ssr_pkg;

   // Lane subset codes; value is the stream_sel encoding.
   typedef enum logic [1:0] {
      SEL_L0   = 2'd0,
      SEL_L0L1 = 2'd1,
      SEL_L0L2 = 2'd2,
      SEL_ALL  = 2'd3
   } strm_sel_e;

   // Index of the final slice of a window for a given subset.
   function automatic logic [1:0] last_slice_idx(input strm_sel_e sel);
      case (sel)
         SEL_L0:   return 2'd0;
         SEL_L0L1: return 2'd1;
         SEL_L0L2: return 2'd1;
         default:  return 2'd3;
      endcase
   endfunction

   // Lane carried by slice number idx for a given subset.
   function automatic logic [1:0] slice_lane(input strm_sel_e sel, input logic [1:0] idx);
      case (sel)
         SEL_L0:   return 2'd0;
         SEL_L0L2: return (idx == 2'd0) ? 2'd0 : 2'd2;
         default:  return idx;
      endcase
   endfunction

endpackage

// File: rtl/ssr_collector.sv
`timescale 1ns/1ps
module ssr_collector #(
   parameter int LANES   = 4,
   parameter int SLICE_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       smp_stb,
   input  logic [LANES-1:0]           smp_bits,
   output logic                       win_load,
   output logic [LANES*SLICE_W-1:0]   win_data
);
   localparam int CNT_W = (SLICE_W > 1) ? $clog2(SLICE_W) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLICE_W - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             at_last;

   assign at_last  = (cnt_q == CNT_LAST);
   assign win_load = smp_stb & at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (smp_stb) begin
         cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
      end
   end

   // One holding register per lane; newest sample enters at bit 0,
   // so the oldest sample of a full window sits at the top bit.
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [SLICE_W-1:0] hold_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_q <= '0;
         end else if (smp_stb) begin
            hold_q <= {hold_q[SLICE_W-2:0], smp_bits[g]};
         end
      end

      assign win_data[g*SLICE_W +: SLICE_W] = {hold_q[SLICE_W-2:0], smp_bits[g]};
   end

endmodule

// File: rtl/ssr_shifter.sv
`timescale 1ns/1ps
module ssr_shifter
   import ssr_pkg::*;
#(
   parameter int LANES   = 4,
   parameter int SLICE_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       win_load,
   input  logic [LANES*SLICE_W-1:0]   win_data,
   input  logic [1:0]                 stream_sel,
   output logic                       ser_dout,
   output logic                       slice_sync,
   output logic                       overrun
);
   localparam int BIT_W = (SLICE_W > 1) ? $clog2(SLICE_W) : 1;
   localparam int SLC_W = 2;
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(SLICE_W - 1);

   strm_sel_e          sel_q;
   logic [SLC_W-1:0]   slc_q;
   logic [BIT_W-1:0]   bit_q;
   logic               busy_q;
   logic               ovr_q;
   logic [SLC_W-1:0]   cur_lane;
   logic               last_bit;
   logic               last_slice;
   logic [LANES-1:0]   lane_msb;

   assign cur_lane   = slice_lane(sel_q, slc_q);
   assign last_bit   = (bit_q == BIT_LAST);
   assign last_slice = (slc_q == last_slice_idx(sel_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= SEL_L0;
         slc_q  <= '0;
         bit_q  <= '0;
         busy_q <= 1'b0;
         ovr_q  <= 1'b0;
      end else if (win_load) begin
         sel_q  <= strm_sel_e'(stream_sel);
         slc_q  <= '0;
         bit_q  <= '0;
         busy_q <= 1'b1;
         if (busy_q && !(last_bit && last_slice)) begin
            ovr_q <= 1'b1;
         end
      end else if (busy_q) begin
         if (last_bit) begin
            bit_q <= '0;
            if (last_slice) begin
               busy_q <= 1'b0;
            end else begin
               slc_q <= slc_q + SLC_W'(1);
            end
         end else begin
            bit_q <= bit_q + BIT_W'(1);
         end
      end
   end

   // Per-lane shift registers; only the lane on the line advances.
   for (genvar g = 0; g < LANES; g++) begin : g_shift
      logic [SLICE_W-1:0] sh_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_q <= '0;
         end else if (win_load) begin
            sh_q <= win_data[g*SLICE_W +: SLICE_W];
         end else if (busy_q && (cur_lane == SLC_W'(g))) begin
            sh_q <= {sh_q[SLICE_W-2:0], 1'b0};
         end
      end

      assign lane_msb[g] = sh_q[SLICE_W-1];
   end

   assign ser_dout   = busy_q & lane_msb[cur_lane];
   assign slice_sync = busy_q & (bit_q == '0);
   assign overrun    = ovr_q;

endmodule

// File: rtl/ssr_tsync_gen.sv
`timescale 1ns/1ps
module ssr_tsync_gen #(
   parameter int TS_MIN = 128,
   parameter int TS_MAX = 16384,
   parameter int PER_W  = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_stb,
   input  logic [PER_W-1:0]  period_req,
   output logic              time_sync
);
   localparam logic [PER_W-1:0] P_LO = PER_W'(TS_MIN);
   localparam logic [PER_W-1:0] P_HI = PER_W'(TS_MAX);

   logic [PER_W-1:0] per_eff;
   logic [PER_W-1:0] tcnt_q;
   logic             wrap;
   logic             ts_q;

   always_comb begin
      if (period_req < P_LO) begin
         per_eff = P_LO;
      end else if (period_req > P_HI) begin
         per_eff = P_HI;
      end else begin
         per_eff = period_req;
      end
   end

   assign wrap = smp_stb && (tcnt_q >= per_eff - PER_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcnt_q <= '0;
         ts_q   <= 1'b0;
      end else begin
         ts_q <= wrap;
         if (smp_stb) begin
            tcnt_q <= wrap ? '0 : tcnt_q + PER_W'(1);
         end
      end
   end

   assign time_sync = ts_q;

endmodule

// File: rtl/sample_stream_serializer.sv
`timescale 1ns/1ps
module sample_stream_serializer #(
   parameter int LANES   = 4,
   parameter int SLICE_W = 16,
   parameter int TS_MIN  = 128,
   parameter int TS_MAX  = 16384,
   localparam int PER_W  = $clog2(TS_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_stb,
   input  logic [LANES-1:0]  smp_bits,
   input  logic [1:0]        stream_sel,
   input  logic [PER_W-1:0]  ts_period,
   output logic              ser_dout,
   output logic              slice_sync,
   output logic              time_sync,
   output logic              overrun
);
   // Elaboration-time parameter checks.
   initial begin : elab_chk
      if (LANES != 4) $fatal(1, "LANES must be 4 to match the subset select");
      if (SLICE_W < 2) $fatal(1, "SLICE_W must be at least 2");
      if (TS_MIN < 2 || TS_MIN > TS_MAX) $fatal(1, "time-marker period limits are inconsistent");
   end

   logic                     win_load;
   logic [LANES*SLICE_W-1:0] win_data;

   ssr_collector #(
      .LANES   (LANES),
      .SLICE_W (SLICE_W)
   ) u_collect (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_stb  (smp_stb),
      .smp_bits (smp_bits),
      .win_load (win_load),
      .win_data (win_data)
   );

   ssr_shifter #(
      .LANES   (LANES),
      .SLICE_W (SLICE_W)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .win_load   (win_load),
      .win_data   (win_data),
      .stream_sel (stream_sel),
      .ser_dout   (ser_dout),
      .slice_sync (slice_sync),
      .overrun    (overrun)
   );

   ssr_tsync_gen #(
      .TS_MIN (TS_MIN),
      .TS_MAX (TS_MAX),
      .PER_W  (PER_W)
   ) u_tsync (
      .clk        (clk),
      .rst_n      (rst_n),
      .smp_stb    (smp_stb),
      .period_req (ts_period),
      .time_sync  (time_sync)
   );

endmodule

// File: rtl/ssr_checker.sv
`timescale 1ns/1ps
module ssr_checker (
   input logic clk,
   input logic rst_n,
   input logic smp_stb,
   input logic win_load,
   input logic slice_sync,
   input logic time_sync,
   input logic overrun
);

   p_load_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
      win_load |=> slice_sync);

   p_sync_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (slice_sync && !win_load) |=> !slice_sync);

   p_ts_after_stb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      time_sync |-> $past(smp_stb));

   p_ts_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      time_sync |=> !time_sync);

   p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   p_ovr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(win_load));

endmodule

bind sample_stream_serializer ssr_checker u_ssr_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .smp_stb    (smp_stb),
   .win_load   (win_load),
   .slice_sync (slice_sync),
   .time_sync  (time_sync),
   .overrun    (overrun)
);

// File: tb/sample_stream_serializer_tb_top.sv
`timescale 1ns/1ps
module sample_stream_serializer_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_stb = 1'b0;
   logic [3:0]  smp_bits = 4'h0;
   logic [1:0]  stream_sel = 2'd0;
   logic [14:0] ts_period = 15'd128;
   logic        ser_dout, slice_sync, time_sync, overrun;

   always #2.5 clk = ~clk;

   sample_stream_serializer dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .smp_stb    (smp_stb),
      .smp_bits   (smp_bits),
      .stream_sel (stream_sel),
      .ts_period  (ts_period),
      .ser_dout   (ser_dout),
      .slice_sync (slice_sync),
      .time_sync  (time_sync),
      .overrun    (overrun)
   );

   typedef struct packed {
      logic [1:0]  sel;
      logic [3:0]  spacing;
      logic        walk;
      logic [14:0] tsp;
      logic [10:0] nwin;
      logic        ovr;
   } scen_t;

   localparam int NSCN = 8;
   localparam scen_t SCN [NSCN] = '{
      '{2'd0, 4'd1, 1'b0, 15'd128,   11'd10,   1'b0},
      '{2'd1, 4'd2, 1'b0, 15'd200,   11'd20,   1'b0},
      '{2'd2, 4'd2, 1'b0, 15'd128,   11'd12,   1'b0},
      '{2'd3, 4'd4, 1'b0, 15'd300,   11'd25,   1'b0},
      '{2'd3, 4'd5, 1'b0, 15'd50,    11'd12,   1'b0},
      '{2'd3, 4'd3, 1'b0, 15'd128,   11'd4,    1'b1},
      '{2'd1, 4'd4, 1'b1, 15'd129,   11'd10,   1'b0},
      '{2'd1, 4'd2, 1'b0, 15'd20000, 11'd1030, 1'b0}
   };

   int n_chk = 0;
   int n_err = 0;
   int cyc   = 0;

   // Bench model state
   bit         wbuf [4][16];
   bit         cwin [4][16];
   int         scnt, k, nsl, tscnt, per_eff;
   bit         pend, act, ts_pend, ovr_exp, clamp_case;
   logic [1:0] sel_lat, cur_sel;
   logic [15:0] lfsr = 16'hACE1;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int n_slices(input logic [1:0] s);
      return (s == 2'd0) ? 1 : (s == 2'd3) ? 4 : 2;
   endfunction

   function automatic int lane_of(input logic [1:0] s, input int idx);
      if (s == 2'd0) return 0;
      if (s == 2'd2) return (idx == 0) ? 0 : 2;
      return idx;
   endfunction

   task automatic chk(input string tag, input logic got, input logic exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %b expected %b (cycle %0d)", tag, got, exp, cyc);
      end
   endtask

   task automatic model_clear();
      scnt = 0; k = 0; nsl = 1; tscnt = 0;
      pend = 0; act = 0; ts_pend = 0; ovr_exp = 0;
      sel_lat = 2'd0; cur_sel = 2'd0;
   endtask

   // One clock: check outputs at the falling edge, then drive next inputs.
   task automatic tick(input bit stb);
      bit exp_d, exp_s, exp_t;
      @(negedge clk);
      if (pend) begin
         if (act && (k != nsl*16 - 1)) ovr_exp = 1;
         for (int l = 0; l < 4; l++)
            for (int b = 0; b < 16; b++) cwin[l][b] = wbuf[l][b];
         cur_sel = sel_lat;
         nsl = n_slices(cur_sel);
         k = 0; act = 1; pend = 0;
      end else if (act) begin
         k++;
         if (k == nsl*16) act = 0;
      end
      exp_t = ts_pend; ts_pend = 0;
      exp_d = act ? cwin[lane_of(cur_sel, k/16)][k%16] : 1'b0;
      exp_s = act && (k%16 == 0);
      chk(act ? "R1 R2 R3 data" : "R4 zero fill", ser_dout, exp_d);
      chk("R5 slice marker", slice_sync, exp_s);
      chk(clamp_case ? "R7 clamped period" : "R6 time marker", time_sync, exp_t);
      chk("R8 overrun", overrun, ovr_exp);
      // drive
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      smp_stb  = stb;
      smp_bits = lfsr[3:0];
      if (stb) begin
         for (int l = 0; l < 4; l++) wbuf[l][scnt] = lfsr[l];
         scnt++;
         if (scnt == 16) begin
            scnt = 0; pend = 1; sel_lat = stream_sel;
         end
         tscnt++;
         if (tscnt == per_eff) begin
            tscnt = 0; ts_pend = 1;
         end
      end
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0; smp_stb = 1'b0;
      repeat (2) @(negedge clk);
      chk("R9 reset dout", ser_dout, 1'b0);
      chk("R9 reset slice marker", slice_sync, 1'b0);
      chk("R9 reset time marker", time_sync, 1'b0);
      chk("R9 reset overrun", overrun, 1'b0);
      model_clear();
      rst_n = 1'b1;
   endtask

   task automatic set_period(input logic [14:0] p);
      ts_period  = p;
      clamp_case = (p < 15'd128) || (p > 15'd16384);
      per_eff    = (p < 15'd128) ? 128 : (p > 15'd16384) ? 16384 : int'(p);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin : main
      model_clear();
      set_period(15'd128);
      // Table-driven scenarios
      for (int s = 0; s < NSCN; s++) begin
         stream_sel = SCN[s].sel;
         set_period(SCN[s].tsp);
         apply_reset();
         for (int w = 0; w < int'(SCN[s].nwin) * 16; w++) begin
            if (SCN[s].walk && (w % 5 == 4)) stream_sel = stream_sel + 2'd1;
            tick(1'b1);
            for (int i = 1; i < int'(SCN[s].spacing); i++) tick(1'b0);
         end
         for (int i = 0; i < 80; i++) tick(1'b0);
         chk("R8 overrun at scenario end", overrun, SCN[s].ovr);
      end

      // Directed: overrun raised, then cleared only by reset (R8, R9)
      stream_sel = 2'd3;
      set_period(15'd128);
      apply_reset();
      for (int w = 0; w < 48; w++) begin
         tick(1'b1); tick(1'b0); tick(1'b0);
      end
      chk("R8 sticky after idle", overrun, 1'b1);
      for (int i = 0; i < 40; i++) tick(1'b0);
      chk("R8 still sticky", overrun, 1'b1);
      stream_sel = 2'd0;
      apply_reset();
      // Directed: 15 strobes after reset yield no data (R9), the 16th starts output
      for (int i = 0; i < 15; i++) begin
         tick(1'b1); tick(1'b0);
      end
      chk("R9 no data before 16th strobe", slice_sync, 1'b0);
      tick(1'b1);
      tick(1'b0);
      chk("R9 first slice after 16th strobe", slice_sync, 1'b1);
      for (int i = 0; i < 30; i++) tick(1'b0);

      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule